// File: doc/BRIEF.md
# External bus hold arbiter

This block decides who drives a shared external memory bus: the local controller, or another master that asks for the bus with an active-low hold request. In master mode, a granted request makes the block float the bus drivers and release the chip-selects to their inactive, pulled-up level. It then signals the grant on an active-low acknowledge pin. The core keeps executing internal work during that time. A core access that needs the external bus stalls, and the block raises an active-low bus request so the other master gives the bus back.

An enable bit turns arbitration on. Clearing the enable never cuts short a hold that is already granted: that hold runs until the request is withdrawn, and only later requests go unanswered. The first time the enable is seen high, the three arbitration pins become dedicated to arbitration until reset.

A mode bit selects slave operation. In slave mode the acknowledge pin becomes an input, so two controllers wire together without glue logic. The slave asks for the bus, drives it only while the acknowledge input shows a grant, and yields when its hold input asks, after the current bus cycle ends.

Top module: `xbus_hold_arb`

## Requirements
- R1: After reset the block is in master mode with the bus driven (`bus_oe`=1, `cs_release`=0). `ack_out_n` and `breq_n` are 1, `core_stall` is 0, `pin_claim` and `ack_drive` are 0.
- R2: `hold_req_n` and `ack_in_n` pass through SYNC_STAGES flops (default 2). In master mode the grant edge is the first edge at which three things hold: the synchronized hold is low, `arb_en`=1 and `cyc_busy`=0. From that edge `bus_oe`=0 and `cs_release`=1. `ack_out_n` goes to 0 one edge later.
- R3: While `cyc_busy`=1 the bus is never floated for a hold. The grant is delayed until the edge at which `cyc_busy` is sampled 0.
- R4: At the edge where the synchronized hold reads released, `ack_out_n` and `breq_n` both return to 1. `bus_oe` returns to 1 one edge later, and `core_stall` clears in that same cycle.
- R5: `core_stall` is 1 exactly when `core_ext_req`=1 and the bus is not driven. Internal-only work (`core_ext_req`=0) never stalls.
- R6: In master mode, `breq_n` is 0 only while the bus is floated for a hold and `core_ext_req`=1.
- R7: With `arb_en`=0, a new hold request is never granted: the bus stays driven and `ack_out_n` stays 1.
- R8: Clearing `arb_en` during a granted hold keeps `ack_out_n`=0 until the hold is withdrawn. The next hold request, made while `arb_en`=0, is ignored.
- R9: `pin_claim` becomes 1 at the first edge that samples `arb_en`=1 and stays 1 until reset. While it is 0, `breq_n`=1, `ack_out_n`=1 and `ack_drive`=0. Otherwise `ack_drive` is 1 in master mode.
- R10: In slave mode, `ack_drive`=0 and `ack_out_n`=1. When idle, `breq_n` is 0 whenever `core_ext_req`=1. The bus is driven (`bus_oe`=1) from the first edge after the synchronized `ack_in_n` shows a grant, and only while it does.
- R11: A slave that drives the bus yields to a synchronized hold (with `arb_en`=1) at the first edge sampling `cyc_busy`=0: `bus_oe`=0 and `breq_n`=1. It stays yielded until the synchronized `ack_in_n` returns to 1. It then asks again if `core_ext_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req_n | input | 1 | Hold request from the other master, active low, asynchronous |
| ack_in_n | input | 1 | Acknowledge pin read as input in slave mode, active low |
| arb_en | input | 1 | Arbitration enable bit |
| slave_mode | input | 1 | 0 master, 1 slave; static configuration |
| core_ext_req | input | 1 | Core has an external bus access pending |
| cyc_busy | input | 1 | A bus cycle is in progress |
| ack_out_n | output | 1 | Hold acknowledge, active low |
| ack_drive | output | 1 | Output enable of the acknowledge pin |
| breq_n | output | 1 | Bus request back to the other master, active low |
| bus_oe | output | 1 | Enable of the address, data and strobe drivers |
| cs_release | output | 1 | Chip-selects released to the inactive pulled-up level |
| pin_claim | output | 1 | Arbitration pins dedicated to arbitration |
| core_stall | output | 1 | Stall of the core's external access |

## Verification
The assertions take `slave_mode` as a static setting that changes only while reset is held. They also take `cyc_busy` as a plain per-cycle level that the arbiter only reads. The bench changes the mode under reset only and drives every input just after a clock edge, so each input value is stable across the next sampling edge. The hold and acknowledge inputs are held at each level for longer than the synchronizer depth. Every transition therefore lands on a cycle that can be predicted by counting registers.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

  // Arbiter states. Master sequence: own -> float -> held -> return -> own.
  // Slave sequence: off -> on -> yield -> off.
  typedef enum logic [2:0] {
    ST_OWN      = 3'd0,
    ST_FLOAT    = 3'd1,
    ST_HELD     = 3'd2,
    ST_RETURN   = 3'd3,
    ST_SL_OFF   = 3'd4,
    ST_SL_ON    = 3'd5,
    ST_SL_YIELD = 3'd6
  } arb_state_e;

  // Bus is lent to the other master (master mode)
  function automatic logic lent_away(arb_state_e s);
    return (s == ST_FLOAT) || (s == ST_HELD);
  endfunction

endpackage

// File: rtl/xbh_rst_sync.sv
module xbh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xbh_sync.sv
module xbh_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/xbh_fsm.sv
module xbh_fsm
  import xbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_mode,
  input  logic       arb_en,
  input  logic       pin_claim,
  input  logic       hold_act,
  input  logic       grant_act,
  input  logic       core_ext_req,
  input  logic       cyc_busy,
  output arb_state_e state_q
);

  arb_state_e state_d;
  logic       yield_ok;

  // A hold is honoured only at a bus cycle boundary and only when enabled
  assign yield_ok = arb_en && hold_act && !cyc_busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN: begin
        if (slave_mode)    state_d = ST_SL_OFF;
        else if (yield_ok) state_d = ST_FLOAT;
      end
      ST_FLOAT:  state_d = ST_HELD;
      ST_HELD: begin
        // enable is not consulted: a granted hold runs to its end
        if (!hold_act) state_d = ST_RETURN;
      end
      ST_RETURN: state_d = ST_OWN;
      ST_SL_OFF: begin
        if (!slave_mode)                                   state_d = ST_OWN;
        else if (pin_claim && core_ext_req && grant_act)   state_d = ST_SL_ON;
      end
      ST_SL_ON: begin
        if (yield_ok)        state_d = ST_SL_YIELD;
        else if (!grant_act) state_d = ST_SL_OFF;
      end
      ST_SL_YIELD: begin
        if (!grant_act) state_d = ST_SL_OFF;
      end
      default: state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/xbh_pinout.sv
module xbh_pinout
  import xbh_pkg::*;
(
  input  arb_state_e state_q,
  input  logic       slave_mode,
  input  logic       pin_claim,
  input  logic       grant_act,
  input  logic       core_ext_req,
  output logic       ack_out_n,
  output logic       ack_drive,
  output logic       breq_n,
  output logic       bus_oe,
  output logic       cs_release,
  output logic       core_stall
);

  logic drive, ack, req;

  always_comb begin
    if (slave_mode) begin
      drive = (state_q == ST_SL_ON) && grant_act;
      ack   = 1'b0;
      req   = ((state_q == ST_SL_OFF) && core_ext_req) || (state_q == ST_SL_ON);
    end else begin
      drive = (state_q == ST_OWN);
      ack   = (state_q == ST_HELD);
      req   = lent_away(state_q) && core_ext_req;
    end
  end

  assign bus_oe     = drive;
  assign cs_release = !drive;
  assign core_stall = core_ext_req && !drive;
  assign ack_out_n  = !(pin_claim && ack);
  assign breq_n     = !(pin_claim && req);
  assign ack_drive  = pin_claim && !slave_mode;

endmodule

// File: rtl/xbus_hold_arb.sv
module xbus_hold_arb
  import xbh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic ack_in_n,
  input  logic arb_en,
  input  logic slave_mode,
  input  logic core_ext_req,
  input  logic cyc_busy,
  output logic ack_out_n,
  output logic ack_drive,
  output logic breq_n,
  output logic bus_oe,
  output logic cs_release,
  output logic pin_claim,
  output logic core_stall
);

  localparam int PinW = 2;

  logic            rst_core_n;
  logic [PinW-1:0] pin_raw, pin_s;
  logic            hold_act, grant_act;
  logic            claim_q;
  arb_state_e      state_q;

  xbh_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign pin_raw = {ack_in_n, hold_req_n};

  xbh_sync #(.WIDTH(PinW), .STAGES(SYNC_STAGES), .RST_VAL({PinW{1'b1}})) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pin_raw),
    .sync_o  (pin_s)
  );

  assign hold_act  = !pin_s[0];
  assign grant_act = !pin_s[1];

  // Sticky pin dedication, enabled by the arbitration enable
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  claim_q <= 1'b0;
    else if (arb_en)  claim_q <= 1'b1;
  end

  assign pin_claim = claim_q;

  xbh_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .slave_mode   (slave_mode),
    .arb_en       (arb_en),
    .pin_claim    (claim_q),
    .hold_act     (hold_act),
    .grant_act    (grant_act),
    .core_ext_req (core_ext_req),
    .cyc_busy     (cyc_busy),
    .state_q      (state_q)
  );

  xbh_pinout u_pins (
    .state_q      (state_q),
    .slave_mode   (slave_mode),
    .pin_claim    (claim_q),
    .grant_act    (grant_act),
    .core_ext_req (core_ext_req),
    .ack_out_n    (ack_out_n),
    .ack_drive    (ack_drive),
    .breq_n       (breq_n),
    .bus_oe       (bus_oe),
    .cs_release   (cs_release),
    .core_stall   (core_stall)
  );

endmodule

// File: rtl/xbh_chk.sv
module xbh_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_mode,
  input logic cyc_busy,
  input logic core_ext_req,
  input logic ack_out_n,
  input logic ack_drive,
  input logic breq_n,
  input logic bus_oe,
  input logic pin_claim,
  input logic core_stall
);

  // R2
  ack_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !ack_out_n) |-> (!bus_oe && !$past(bus_oe)));

  // R3
  float_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $fell(bus_oe)) |-> !$past(cyc_busy));

  // R4
  bus_back_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $rose(bus_oe)) |-> (ack_out_n && $past(ack_out_n) && breq_n));

  // R5
  no_stall_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !core_stall);

  // R6
  breq_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!breq_n && !slave_mode) |-> core_ext_req);

  // R9
  claim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_claim) |-> pin_claim);

  // R9
  pins_quiet_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_claim |-> (breq_n && ack_out_n && !ack_drive));

  // R10
  slave_ack_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!ack_drive && ack_out_n));

endmodule

bind xbus_hold_arb xbh_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .slave_mode   (slave_mode),
  .cyc_busy     (cyc_busy),
  .core_ext_req (core_ext_req),
  .ack_out_n    (ack_out_n),
  .ack_drive    (ack_drive),
  .breq_n       (breq_n),
  .bus_oe       (bus_oe),
  .pin_claim    (pin_claim),
  .core_stall   (core_stall)
);

// File: tb/sim_xbus_hold_arb.sv
`timescale 1ns/1ps
module sim_xbus_hold_arb;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n, hold_req_n, ack_in_n, arb_en, slave_mode, core_ext_req, cyc_busy;
  logic ack_out_n, ack_drive, breq_n, bus_oe, cs_release, pin_claim, core_stall;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  xbus_hold_arb #(.SYNC_STAGES(SYNC), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .ack_in_n(ack_in_n),
    .arb_en(arb_en), .slave_mode(slave_mode), .core_ext_req(core_ext_req),
    .cyc_busy(cyc_busy), .ack_out_n(ack_out_n), .ack_drive(ack_drive),
    .breq_n(breq_n), .bus_oe(bus_oe), .cs_release(cs_release),
    .pin_claim(pin_claim), .core_stall(core_stall)
  );

  task automatic chk(string tag, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(logic slv);
    rst_n = 1'b0; hold_req_n = 1'b1; ack_in_n = 1'b1; arb_en = 1'b0;
    slave_mode = slv; core_ext_req = 1'b0; cyc_busy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(5);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // ---------- R1 reset state ----------
    do_reset(1'b0);
    chk("R1 bus_oe", bus_oe, 1'b1);
    chk("R1 cs_release", cs_release, 1'b0);
    chk("R1 ack_out_n", ack_out_n, 1'b1);
    chk("R1 breq_n", breq_n, 1'b1);
    chk("R1 core_stall", core_stall, 1'b0);
    chk("R1 pin_claim", pin_claim, 1'b0);
    chk("R1 ack_drive", ack_drive, 1'b0);

    // ---------- R7 / R9: hold before any enable ----------
    hold_req_n = 1'b0; core_ext_req = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      step(1);
      chk("R7 no grant bus_oe", bus_oe, 1'b1);
      chk("R7 no grant ack", ack_out_n, 1'b1);
      chk("R9 unclaimed breq", breq_n, 1'b1);
      chk("R9 unclaimed claim", pin_claim, 1'b0);
    end
    hold_req_n = 1'b1; core_ext_req = 1'b0;
    step(SYNC + 2);

    // ---------- R9 claim is sticky ----------
    arb_en = 1'b1;
    step(1);
    chk("R9 claim set", pin_claim, 1'b1);
    chk("R9 ack_drive master", ack_drive, 1'b1);
    arb_en = 1'b0;
    step(3);
    chk("R9 claim kept", pin_claim, 1'b1);
    chk("R9 ack_drive kept", ack_drive, 1'b1);

    // ---------- R2 R3 R4 R5 R6 sweep ----------
    arb_en = 1'b1;
    for (int rq = 0; rq < 2; rq++) begin
      for (int bl = 0; bl <= 6; bl++) begin
        automatic int fl = (bl + 1 > SYNC + 1) ? bl + 1 : SYNC + 1;
        automatic logic r = (rq == 1);
        core_ext_req = r;
        cyc_busy     = (bl > 0);
        hold_req_n   = 1'b0;
        for (int c = 1; c <= 10; c++) begin
          step(1);
          if (c == bl) cyc_busy = 1'b0;
          chk("R2/R3 bus_oe", bus_oe, c < fl);
          chk("R2 cs_release", cs_release, c >= fl);
          chk("R2 ack_out_n", ack_out_n, !(c >= fl + 1));
          chk("R6 breq_n", breq_n, !(r && c >= fl));
          chk("R5 stall", core_stall, r && c >= fl);
        end
        hold_req_n = 1'b1;
        for (int c = 1; c <= 5; c++) begin
          step(1);
          chk("R4 ack release", ack_out_n, !(c < SYNC + 1));
          chk("R4 breq release", breq_n, !(r && c < SYNC + 1));
          chk("R4 bus back", bus_oe, c >= SYNC + 2);
          chk("R4/R5 stall release", core_stall, r && c < SYNC + 2);
        end
        core_ext_req = 1'b0;
        step(2);
      end
    end

    // ---------- R8 sticky hold after enable cleared ----------
    hold_req_n = 1'b0;
    step(SYNC + 2);
    chk("R8 granted", ack_out_n, 1'b0);
    arb_en = 1'b0;
    for (int c = 1; c <= 5; c++) begin
      step(1);
      chk("R8 hold continues", ack_out_n, 1'b0);
      chk("R8 bus floated", bus_oe, 1'b0);
    end
    hold_req_n = 1'b1;
    step(SYNC + 2);
    chk("R8 hold ended", ack_out_n, 1'b1);
    chk("R8 bus back", bus_oe, 1'b1);
    hold_req_n = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      step(1);
      chk("R8/R7 next hold ignored", bus_oe, 1'b1);
      chk("R8/R7 next ack quiet", ack_out_n, 1'b1);
    end
    hold_req_n = 1'b1;
    step(SYNC + 1);

    // ---------- R10 R11 slave mode ----------
    do_reset(1'b1);
    arb_en = 1'b1;
    step(1);
    chk("R10 ack_drive off", ack_drive, 1'b0);
    chk("R10 ack_out_n high", ack_out_n, 1'b1);
    chk("R10 idle floated", bus_oe, 1'b0);
    chk("R10 idle no breq", breq_n, 1'b1);
    core_ext_req = 1'b1;
    #1;
    chk("R10 breq on request", breq_n, 1'b0);
    chk("R10 stall waiting", core_stall, 1'b1);
    ack_in_n = 1'b0;
    step(SYNC);
    chk("R10 not yet driving", bus_oe, 1'b0);
    step(1);
    chk("R10 driving on grant", bus_oe, 1'b1);
    chk("R10 stall cleared", core_stall, 1'b0);
    cyc_busy = 1'b1; hold_req_n = 1'b0;
    step(SYNC + 2);
    chk("R11 keeps bus while busy", bus_oe, 1'b1);
    cyc_busy = 1'b0;
    step(1);
    chk("R11 yield floats", bus_oe, 1'b0);
    chk("R11 yield drops breq", breq_n, 1'b1);
    hold_req_n = 1'b1;
    step(4);
    chk("R11 stays yielded", breq_n, 1'b1);
    ack_in_n = 1'b1;
    step(SYNC);
    chk("R11 waits for ack release", breq_n, 1'b1);
    step(1);
    chk("R11 asks again", breq_n, 1'b0);
    chk("R10 floated after yield", bus_oe, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule